// File: doc/BRIEF.md
# Continuous-Conversion ADC Serial Reader

This block is a serial master that pulls results out of a delta-sigma converter running in continuous-conversion mode. Between conversions the converter holds its data-out line high. When a new result is ready it pulls that line low. The reader waits for the low level, then clocks an 8-bit command phase that clears the ready flag. It then clocks a 24-bit result word in MSB first and splits the word into a conversion value and two status flags.

The converter can run at 20-bit or 16-bit resolution, and the two resolutions place different fixed filler bits in the low part of the word. The reader checks those filler bits and reports a mismatch as a format error. The serial clock is produced from the system clock by an elaboration-time divider. The divider is sized so that the serial clock never runs faster than the converter's limit, 2 MHz by default. The reader does not count conversion time: the first conversion after start-up takes longer than the rest, and the reader simply waits for the ready level each time.

Top module: `adc_stream_reader`

## Requirements
- R1: While rst_ni is low, and right after it is released, sclk_o, sdi_o and result_valid_o are all low and the reader is idle.
- R2: A frame starts only when en_i is high and the registered SDO has read low on two consecutive system clocks while idle. A one-cycle low pulse on sdo_i does not start a frame. A low sdo_i while en_i is low does not start a frame.
- R3: sclk_o idles low. A frame is 8 command periods followed by 24 data periods, which is 32 rising edges. Every high phase and every low phase inside a frame lasts exactly HALF_DIV system clocks, where HALF_DIV = ceil(CLK_HZ / (2 * SCLK_MAX_HZ)).
- R4: During the command phase sdi_o carries CMD_BYTE MSB first. The first bit is present from the start of the frame, and each following bit appears after a falling SCLK edge. The default CMD_BYTE is 0x00. Outside the command phase sdi_o is low.
- R5: In the data phase sdo_i is sampled at each rising SCLK edge and shifted in MSB first, giving a 24-bit word w[23:0].
- R6: When res16_i is 0 at frame start (20-bit mode), data_o = w[23:4], osc_det_o = w[1] and ovf_o = w[0].
- R7: When res16_i is 1 at frame start (16-bit mode), data_o = {4'b0000, w[23:8]}, osc_det_o = w[1] and ovf_o = w[0].
- R8: format_error_o is high exactly when the filler bits are wrong. In 20-bit mode the filler w[3:2] must be 2'b00. In 16-bit mode the filler w[7:2] must be 6'b111100.
- R9: result_valid_o is high for exactly one system clock per frame, two clocks after the last falling SCLK edge. data_o, osc_det_o, ovf_o and format_error_o take their new values in that cycle and hold them until the next result.
- R10: res16_i is captured when a frame starts. Changing it during the frame has no effect on that frame's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Allows new frames to start |
| res16_i | input | 1 | 1 selects the 16-bit word layout, 0 selects the 20-bit layout |
| sdo_i | input | 1 | Converter data out, which also carries the ready flag |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Serial command line to the converter |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| data_o | output | 20 | Conversion value, zero-extended in 16-bit mode |
| osc_det_o | output | 1 | Oscillation-detect flag from the word |
| ovf_o | output | 1 | Overflow flag from the word |
| format_error_o | output | 1 | Filler bits did not match the selected layout |

## Verification
The bench builds the reader with SCLK_MAX_HZ set to a quarter of CLK_HZ. This gives HALF_DIV = 2, so a whole 32-period frame takes about 130 system clocks. That makes room for many frames, idle glitches and a mid-frame resolution change within a short run. The bench also sets CMD_BYTE to 0x5A instead of the all-zero default. With a non-zero byte, the MSB-first order and the falling-edge timing on sdi_o can be seen and checked. The default divider of 25 is only reached through the half-period checker, which counts cycles against the parameter rather than a fixed number.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CMD_BITS  = 8;
  localparam int unsigned WORD_BITS = 24;
  localparam int unsigned DATA_BITS = 20;
  localparam int unsigned CNT_W     = $clog2(WORD_BITS);

  localparam int unsigned OD_POS = 1;
  localparam int unsigned OF_POS = 0;

  localparam logic [1:0] FILL_20 = 2'b00;
  localparam logic [5:0] FILL_16 = 6'b111100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_DONE
  } rd_state_e;

  typedef struct packed {
    logic [DATA_BITS-1:0] data;
    logic                 osc_det;
    logic                 ovf;
    logic                 fmt_err;
  } rd_result_t;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == LAST);
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_ready_det.sv
module adc_rd_ready_det #(
  parameter int unsigned LOW_SAMPLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sdo_i,
  input  logic arm_i,
  input  logic en_i,
  output logic start_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic                   sdo_q;
  logic [LOW_SAMPLES-1:0] hist_q;
  logic [LOW_SAMPLES-1:0] hist_d;

  generate
    if (LOW_SAMPLES == 1) begin : g_single
      assign hist_d = sdo_q;
    end else begin : g_multi
      assign hist_d = {hist_q[LOW_SAMPLES-2:0], sdo_q};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdo_q  <= 1'b1;
      hist_q <= '1;
    end else begin
      sdo_q  <= sdo_i;
      // stale samples from a finished frame must not count
      hist_q <= arm_i ? hist_d : '1;
    end
  end

  assign start_o = en_i && arm_i && ~|hist_q;
endmodule

// File: rtl/adc_rd_unpack.sv
module adc_rd_unpack
  import adc_rd_pkg::*;
(
  input  logic [WORD_BITS-1:0] word_i,
  input  logic                 res16_i,
  output rd_result_t           result_o
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    result_o.osc_det = word_i[OD_POS];
    result_o.ovf     = word_i[OF_POS];
    if (res16_i) begin
      result_o.data    = {4'b0000, word_i[23:8]};
      result_o.fmt_err = (word_i[7:2] != FILL_16);
    end else begin
      result_o.data    = word_i[23:4];
      result_o.fmt_err = (word_i[3:2] != FILL_20);
    end
  end
endmodule

// File: rtl/adc_stream_reader.sv
module adc_stream_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned SCLK_MAX_HZ = 2_000_000,
  parameter logic [7:0]  CMD_BYTE    = 8'h00
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 res16_i,
  input  logic                 sdo_i,
  output logic                 sclk_o,
  output logic                 sdi_o,
  output logic                 result_valid_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 osc_det_o,
  output logic                 ovf_o,
  output logic                 format_error_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned HALF_RAW = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int unsigned HALF_DIV = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORD_BITS - 1);

  rd_state_e            state_q;
  logic [CNT_W-1:0]     bit_q;
  logic [WORD_BITS-1:0] word_q;
  logic [CMD_BITS-1:0]  cmd_q;
  logic                 sdi_q;
  logic                 res16_q;
  logic                 valid_q;
  rd_result_t           res_q;
  rd_result_t           res_d;
  logic                 start;
  logic                 run;
  logic                 rise;
  logic                 fall;

  assign run = (state_q == ST_CMD) || (state_q == ST_DATA);

  adc_rd_ready_det #(.LOW_SAMPLES(2)) u_ready (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sdo_i  (sdo_i),
    .arm_i  (state_q == ST_IDLE),
    .en_i   (en_i),
    .start_o(start)
  );

  adc_rd_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .sclk_o(sclk_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  adc_rd_unpack u_unpack (
    .word_i  (word_q),
    .res16_i (res16_q),
    .result_o(res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      word_q  <= '0;
      cmd_q   <= '0;
      sdi_q   <= 1'b0;
      res16_q <= 1'b0;
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_CMD;
            bit_q   <= '0;
            cmd_q   <= CMD_BYTE;
            sdi_q   <= CMD_BYTE[CMD_BITS-1];
            res16_q <= res16_i;
          end
        end
        ST_CMD: begin
          if (fall) begin
            if (bit_q == LAST_CMD) begin
              state_q <= ST_DATA;
              bit_q   <= '0;
              sdi_q   <= 1'b0;
            end else begin
              bit_q   <= bit_q + 1'b1;
              sdi_q   <= cmd_q[CMD_BITS-2];
              cmd_q   <= {cmd_q[CMD_BITS-2:0], 1'b0};
            end
          end
        end
        ST_DATA: begin
          if (rise) word_q <= {word_q[WORD_BITS-2:0], sdo_i};
          if (fall) begin
            if (bit_q == LAST_WORD) begin
              state_q <= ST_DONE;
              bit_q   <= '0;
            end else begin
              bit_q   <= bit_q + 1'b1;
            end
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
          valid_q <= 1'b1;
          res_q   <= res_d;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sdi_o          = sdi_q;
  assign result_valid_o = valid_q;
  assign data_o         = res_q.data;
  assign osc_det_o      = res_q.osc_det;
  assign ovf_o          = res_q.ovf;
  assign format_error_o = res_q.fmt_err;
endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker
  import adc_rd_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input logic      clk_i,
  input logic      rst_ni,
  input logic      en_i,
  input logic      sclk_o,
  input logic      sdi_o,
  input logic      result_valid_o,
  input rd_state_e state_q,
  input logic      res16_q
);
  timeunit 1ns;
  timeprecision 1ps;

  logic        sclk_prev;
  logic [31:0] hold_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev <= 1'b0;
      hold_cnt  <= '0;
    end else begin
      sclk_prev <= sclk_o;
      if (state_q != ST_CMD && state_q != ST_DATA) hold_cnt <= '0;
      else if (sclk_o != sclk_prev)               hold_cnt <= 32'd1;
      else                                        hold_cnt <= hold_cnt + 32'd1;
    end
  end

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sclk_o);  // R3
  AST_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != sclk_prev) |-> (hold_cnt == HALF_DIV));  // R3
  AST_SDI_CMD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_CMD) |-> !sdi_o);  // R4
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);  // R9
  AST_VALID_FROM_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> ($past(state_q) == ST_DONE));  // R9
  AST_START_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD && $past(state_q) == ST_IDLE) |-> $past(en_i));  // R2
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(res16_q));  // R10
endmodule

bind adc_stream_reader adc_rd_checker #(.HALF_DIV(HALF_DIV)) u_adc_rd_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .sclk_o        (sclk_o),
  .sdi_o         (sdi_o),
  .result_valid_o(result_valid_o),
  .state_q       (state_q),
  .res16_q       (res16_q)
);

// File: tb/tb_adc_stream_reader.sv
module tb_adc_stream_reader;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned TB_CLK_HZ  = 125_000_000;
  localparam int unsigned TB_SCLK_HZ = 31_250_000;
  localparam logic [7:0]  TB_CMD     = 8'h5A;
  localparam int          HD = (TB_CLK_HZ + 2 * TB_SCLK_HZ - 1) / (2 * TB_SCLK_HZ);

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        res16_i = 1'b0;
  logic        sdo_i = 1'b1;
  logic        sclk_o, sdi_o, result_valid_o, osc_det_o, ovf_o, format_error_o;
  logic [19:0] data_o;

  adc_stream_reader #(
    .CLK_HZ(TB_CLK_HZ), .SCLK_MAX_HZ(TB_SCLK_HZ), .CMD_BYTE(TB_CMD)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .res16_i(res16_i), .sdo_i(sdo_i),
    .sclk_o(sclk_o), .sdi_o(sdi_o), .result_valid_o(result_valid_o), .data_o(data_o),
    .osc_det_o(osc_det_o), .ovf_o(ovf_o), .format_error_o(format_error_o)
  );

  always #4ns clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {data[19:0], od, of, err}
  function automatic logic [22:0] decode(input logic [23:0] w, input logic m16);
    logic [19:0] d;
    logic        e;
    if (m16) begin
      d = {4'h0, w[23:8]};
      e = (w[7:2] != 6'b111100);
    end else begin
      d = w[23:4];
      e = (w[3:2] != 2'b00);
    end
    return {d, w[1], w[0], e};
  endfunction

  // converter model and edge counters
  logic [23:0] conv_word = '0;
  int  conv_req = 0, conv_seen = 0, falls = 0, rises = 0, valids = 0;
  bit  conv_act = 0, prev_sclk = 0;
  logic idle_sdo = 1'b1;

  always @(negedge clk_i) begin
    if (!prev_sclk && sclk_o) rises++;
    if (result_valid_o) valids++;
    if (conv_req != conv_seen) begin
      conv_seen = conv_req;
      conv_act  = 1;
      falls     = 0;
    end else if (conv_act && prev_sclk && !sclk_o) begin
      falls++;
    end
    prev_sclk = sclk_o;
    if (conv_act && falls == 32) conv_act = 0;
    sdo_i <= conv_act ? ((falls < 8) ? 1'b0 : conv_word[31-falls]) : idle_sdo;
  end

  // cycle reference model
  int          m_st = 0, m_cnt = 0, m_bit = 0;
  bit          m_sclk = 0, m_sdor = 1, m_h0 = 1, m_h1 = 1, m_valid = 0, m_mode = 0;
  logic [23:0] m_word = '0;
  logic [22:0] m_res = '0;

  always @(posedge clk_i) begin : model
    bit tick, rise, fall, start;
    cyc++;
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_bit = 0; m_sclk = 0; m_sdor = 1; m_h0 = 1; m_h1 = 1;
      m_valid = 0; m_mode = 0; m_word = '0; m_res = '0;
    end else begin
      start = (m_st == 0) && en_i && !m_h0 && !m_h1;
      tick  = (m_st == 1 || m_st == 2) && (m_cnt == HD - 1);
      rise  = tick && !m_sclk;
      fall  = tick && m_sclk;
      if (m_st == 0) begin m_h1 = m_h0; m_h0 = m_sdor; end
      else begin m_h1 = 1; m_h0 = 1; end
      m_sdor = sdo_i;
      if (m_st == 1 || m_st == 2) begin
        if (tick) begin m_cnt = 0; m_sclk = !m_sclk; end
        else m_cnt++;
      end else begin
        m_cnt = 0; m_sclk = 0;
      end
      m_valid = 0;
      case (m_st)
        0: if (start) begin m_st = 1; m_bit = 0; m_mode = res16_i; end
        1: if (fall) begin
             if (m_bit == 7) begin m_st = 2; m_bit = 0; end
             else m_bit++;
           end
        2: begin
             if (rise) m_word = {m_word[22:0], sdo_i};
             if (fall) begin
               if (m_bit == 23) begin m_st = 3; m_bit = 0; end
               else m_bit++;
             end
           end
        default: begin m_st = 0; m_valid = 1; m_res = decode(m_word, m_mode); end
      endcase
    end
  end

  always @(negedge clk_i) begin
    logic exp_sdi;
    if (rst_ni) begin
      exp_sdi = (m_st == 1) ? TB_CMD[7-m_bit] : 1'b0;
      chk(sclk_o === m_sclk, "R3", "sclk cycle", sclk_o, m_sclk);
      chk(sdi_o === exp_sdi, "R4", "sdi cycle", sdi_o, exp_sdi);
      chk(result_valid_o === m_valid, "R9", "valid cycle", result_valid_o, m_valid);
      if (m_valid)
        chk({data_o, osc_det_o, ovf_o, format_error_o} === m_res, "R5", "fields cycle",
            {data_o, osc_det_o, ovf_o, format_error_o}, m_res);
    end
  end

  always @(posedge clk_i) begin
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_frame(input logic [23:0] w, input logic m16, input bit flip, input bit hold_en);
    int r0 = rises;
    int v0 = valids;
    bit got = 0;
    logic [22:0] e = decode(w, m16);
    logic [19:0] d0;
    @(negedge clk_i);
    res16_i   = m16;
    conv_word = w;
    conv_req++;
    if (hold_en) begin
      en_i = 1'b0;
      repeat (30) @(negedge clk_i);
      chk(rises == r0, "R2", "no sclk while disabled", rises - r0, 0);
      en_i = 1'b1;
    end
    if (flip) begin
      repeat (40) @(negedge clk_i);
      res16_i = ~m16;  // R10: must be ignored
    end
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk_i);
      if (result_valid_o) got = 1;
    end
    chk(got, "R9", "valid seen", got, 1);
    chk(data_o == e[22:3], m16 ? "R7" : "R6", flip ? "data after flip R10" : "data",
        data_o, e[22:3]);
    chk(osc_det_o == e[2], m16 ? "R7" : "R6", "osc_det", osc_det_o, e[2]);
    chk(ovf_o == e[1], m16 ? "R7" : "R6", "ovf", ovf_o, e[1]);
    chk(format_error_o == e[0], "R8", "format_error", format_error_o, e[0]);
    d0 = data_o;
    repeat (4) @(negedge clk_i);
    chk(valids - v0 == 1, "R9", "one strobe per frame", valids - v0, 1);
    chk(rises - r0 == 32, "R3", "rising edges per frame", rises - r0, 32);
    chk(data_o == d0, "R9", "data held", data_o, d0);
    res16_i = m16;
  endtask

  initial begin
    int r0;
    repeat (3) @(negedge clk_i);
    chk(sclk_o === 1'b0, "R1", "sclk in reset", sclk_o, 0);
    chk(sdi_o === 1'b0, "R1", "sdi in reset", sdi_o, 0);
    chk(result_valid_o === 1'b0, "R1", "valid in reset", result_valid_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(sclk_o === 1'b0 && result_valid_o === 1'b0, "R1", "idle after reset",
        {sclk_o, result_valid_o}, 0);
    en_i = 1'b1;
    repeat (4) @(negedge clk_i);

    do_frame({20'hA5C3F, 2'b00, 1'b1, 1'b0}, 1'b0, 0, 0);  // R6
    do_frame({16'hBEEF, 6'b111100, 2'b01}, 1'b1, 0, 0);     // R7
    do_frame({16'h1234, 6'b101100, 2'b11}, 1'b1, 0, 0);     // R8 bad 16-bit filler
    do_frame({20'h00001, 2'b10, 2'b00}, 1'b0, 0, 0);        // R8 bad 20-bit filler
    do_frame({20'h12345, 2'b00, 2'b11}, 1'b0, 1, 0);        // R10 mode flip
    do_frame({16'h8001, 6'b111100, 2'b10}, 1'b1, 0, 1);     // R2 enable gating

    // R2: single-cycle low pulse must not start a frame
    r0 = rises;
    @(negedge clk_i);
    idle_sdo = 1'b0;
    @(negedge clk_i);
    idle_sdo = 1'b1;
    repeat (30) @(negedge clk_i);
    chk(rises == r0, "R2", "glitch ignored", rises - r0, 0);
    chk(result_valid_o === 1'b0, "R2", "no result after glitch", result_valid_o, 0);

    do_frame({20'hFFFFF, 2'b00, 2'b11}, 1'b0, 0, 0);        // R5 all ones
    repeat (5) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule